// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as packed BCD counters. A sub-second counter advances on each pulse of a prescaled tick input. When it wraps, the seconds advance, and carries ripple through minutes, hours, weekday, day of month, month and a two-digit year. The day counter knows the length of each month and detects leap years for February.

Software reaches the block through a byte-wide register port with a four-bit word index. Counters can be loaded while the clock is stopped. Counting resumes once both the enable bit and the start bit are set. A carry flag is raised on every seconds advance, and software can clear it by writing zero. This supports a coherent read: clear the flag, read the counters, and retry if the flag was raised again in the meantime. The flag can also raise an interrupt. Two self-clearing controls are provided: one resets the sub-second prescaler, and one rounds the seconds to the nearest minute.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the sub-second, second, minute, hour, weekday and year counters read 0x00, day and month read 0x01, both control registers read 0x00 and carryIrq is low.
- R2: The sub-second counter (index 0) advances on a tick only while control-2 bit 3 (enable) and bit 0 (start) are both 1; it wraps from TICKS_PER_SEC-1 to 0 and that wrap advances the seconds; with either bit clear, ticks change nothing.
- R3: Seconds and minutes wrap 0x59 to 0x00, hours wrap 0x23 to 0x00, and the hour wrap advances both the weekday (0x00..0x06) and the day.
- R4: The day wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months; month wraps 0x12 to 0x01 and advances the year; the year wraps 0x99 to 0x00.
- R5: February (month 0x02) ends at 0x29 when the two-digit year, taken as a decimal number, is divisible by 4, and at 0x28 otherwise.
- R6: Control-1 bit 7 (carry flag) is set on every seconds advance caused by counting. Writing control-1 with bit 7 = 0 clears it, and writing bit 7 = 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R7: carryIrq is high exactly when the carry flag and control-1 bit 4 (carry interrupt enable) are both 1.
- R8: Writing control-2 with bit 1 = 1 clears the sub-second counter on the next cycle; the bit reads back as 0.
- R9: Writing control-2 with bit 2 = 1 rounds the seconds on the next cycle, whether or not the clock runs. Values 0x00..0x29 become 0x00. Values 0x30..0x59 become 0x00 and carry into the minutes, and onward. The bit reads back as 0.
- R10: Word indices 1..7 hold second, minute, hour, weekday, day, month and year and can be read and written. Index 14 is control 1 and index 15 is control 2. Indices 8..13 read 0x00 and ignore writes.
- R11: Each BCD counter carries its units digit into its tens digit, so x9 is followed by (x+1)0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the prescaled counting rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word index for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr |
| carryIrq | output | 1 | Carry interrupt request |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, so one second costs four tick cycles. This makes the sub-second wrap, the carry flag and the prescaler reset observable within a few cycles. Every calendar boundary is reached by loading the counters one second short of it while stopped and then running one second. This covers end of year, 30- and 31-day months, February in leap and non-leap years, and BCD digit carries. The rounding control is tested below, at and above the half-minute point, including a cascade into the hour.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam logic [3:0] IDX_SUB  = 4'd0;
  localparam logic [3:0] IDX_SEC  = 4'd1;
  localparam logic [3:0] IDX_YEAR = 4'd7;
  localparam logic [3:0] IDX_CTL1 = 4'd14;
  localparam logic [3:0] IDX_CTL2 = 4'd15;

  typedef struct packed {
    logic       count;
    logic       adjust;
    logic       preReset;
    logic       wrEn;
    logic [3:0] wrIdx;
    logic [7:0] wrData;
  } ctlStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    logic [6:0] b;
    b = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] monthEnd(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  input  logic       secCarry,
  output ctlStrobe_t strb,
  output logic [7:0] ctl1Rd,
  output logic [7:0] ctl2Rd,
  output logic       carryIrq
);
  logic enable, start, cie, carryFlag, adjPend, presetPend;
  logic wrCtl1, wrCtl2;

  assign wrCtl1 = wrEn && (addr == IDX_CTL1);
  assign wrCtl2 = wrEn && (addr == IDX_CTL2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      start      <= 1'b0;
      cie        <= 1'b0;
      carryFlag  <= 1'b0;
      adjPend    <= 1'b0;
      presetPend <= 1'b0;
    end else begin
      adjPend    <= wrCtl2 && wrData[2];
      presetPend <= wrCtl2 && wrData[1];
      if (wrCtl2) begin
        enable <= wrData[3];
        start  <= wrData[0];
      end
      if (wrCtl1) cie <= wrData[4];
      if (secCarry) carryFlag <= 1'b1;
      else if (wrCtl1 && !wrData[7]) carryFlag <= 1'b0;
    end
  end

  always_comb begin
    strb.count    = enable && start && tick;
    strb.adjust   = adjPend;
    strb.preReset = presetPend;
    strb.wrEn     = wrEn;
    strb.wrIdx    = addr;
    strb.wrData   = wrData;
  end

  assign ctl1Rd   = {carryFlag, 2'b00, cie, 4'b0000};
  assign ctl2Rd   = {4'b0000, enable, 2'b00, start};
  assign carryIrq = carryFlag && cie;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    secCarry |=> carryFlag);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    carryIrq |-> (ctl1Rd[7] && ctl1Rd[4]));

  // R2
  carry_only_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    secCarry |-> strb.count);
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 128,
  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  output logic [SUB_W-1:0] subSec,
  output logic [6:0][7:0]  calVal,
  output logic             secCarry
);
  localparam int FIELDS = 7;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  logic [FIELDS-1:0][7:0] cnt, topVal, lowVal;
  logic [FIELDS-1:0]      inc, wrap;
  logic                   secAdvance;

  // Sub-second prescaled counter.
  always_ff @(posedge clk) begin
    if (!rstN)              subSec <= '0;
    else if (strb.preReset) subSec <= '0;
    else if (strb.count)    subSec <= (subSec == SUB_LAST) ? '0 : subSec + 1'b1;
  end

  assign secAdvance = strb.count && !strb.preReset && (subSec == SUB_LAST);
  assign secCarry   = secAdvance;

  // Field order: sec, min, hour, weekday, day, month, year.
  always_comb begin
    topVal = {8'h99, 8'h12, monthEnd(cnt[5], cnt[6]), 8'h06, 8'h23, 8'h59, 8'h59};
    lowVal = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
    inc[0] = secAdvance && !strb.adjust;
    for (int i = 0; i < FIELDS; i++) begin
      wrap[i] = inc[i] && (cnt[i] == topVal[i]);
      if (i + 1 < FIELDS) begin
        case (i + 1)
          1:       inc[1] = strb.adjust ? (cnt[0] >= 8'h30) : wrap[0];
          4:       inc[4] = wrap[2];
          default: inc[i + 1] = wrap[i];
        endcase
      end
    end
  end

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)
        cnt[i] <= lowVal[i];
      else if (strb.wrEn && strb.wrIdx == 4'(i + 1))
        cnt[i] <= strb.wrData;
      else if (i == 0 && strb.adjust)
        cnt[i] <= 8'h00;
      else if (inc[i])
        cnt[i] <= wrap[i] ? lowVal[i] : bcdInc(cnt[i]);
    end
  end

  assign calVal = cnt;

  // R8
  prescale_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.preReset |=> (subSec == '0));

  // R9
  adjust_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adjust && !(strb.wrEn && strb.wrIdx == IDX_SEC)) |=> (cnt[0] == 8'h00));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.count && !strb.wrEn && !strb.adjust && !strb.preReset)
      |=> ($stable(cnt) && $stable(subSec)));
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 128
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       carryIrq
);
  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  ctlStrobe_t       strb;
  logic [SUB_W-1:0] subSec;
  logic [6:0][7:0]  calVal;
  logic             secCarry;
  logic [7:0]       ctl1Rd, ctl2Rd;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .secCarry(secCarry), .strb(strb),
    .ctl1Rd(ctl1Rd), .ctl2Rd(ctl2Rd), .carryIrq(carryIrq)
  );

  rtc_datapath #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .subSec(subSec), .calVal(calVal), .secCarry(secCarry)
  );

  always_comb begin
    rdData = 8'h00;
    if (addr == IDX_SUB)                        rdData = 8'(subSec);
    else if (addr >= IDX_SEC && addr <= IDX_YEAR) rdData = calVal[3'(addr - 4'd1)];
    else if (addr == IDX_CTL1)                  rdData = ctl1Rd;
    else if (addr == IDX_CTL2)                  rdData = ctl2Rd;
  end
endmodule

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [3:0] monAddr = '0;
  logic [3:0] addr;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       carryIrq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] qAddr[$];
  logic [7:0] qExp[$];
  string      qTag[$];

  assign addr = wrEn ? wrAddr : monAddr;

  always #2.5 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(4)) i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .carryIrq(carryIrq)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(negedge clk);
      if (qAddr.size() > 0) begin
        logic [4:0] a;
        logic [7:0] e, act;
        string t;
        a = qAddr.pop_front();
        e = qExp.pop_front();
        t = qTag.pop_front();
        monAddr = a[3:0];
        #1;
        act = (a == 5'd16) ? {7'b0, carryIrq} : rdData;
        checks++;
        if (act !== e) begin
          fails++;
          $display("FAIL %s idx %0d: actual %h expected %h", t, a, act, e);
        end
      end
    end
  end

  task automatic expectReg(input logic [4:0] a, input logic [7:0] e, input string t);
    qAddr.push_back(a);
    qExp.push_back(e);
    qTag.push_back(t);
    while (qAddr.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                         input logic [7:0] y);
    writeReg(4'd15, 8'h00);
    writeReg(4'd1, s);
    writeReg(4'd2, m);
    writeReg(4'd3, h);
    writeReg(4'd4, w);
    writeReg(4'd5, d);
    writeReg(4'd6, mo);
    writeReg(4'd7, y);
    writeReg(4'd15, 8'h09);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expectReg(5'd0, 8'h00, "R1");
    expectReg(5'd1, 8'h00, "R1");
    expectReg(5'd5, 8'h01, "R1");
    expectReg(5'd6, 8'h01, "R1");
    expectReg(5'd14, 8'h00, "R1");
    expectReg(5'd15, 8'h00, "R1");
    expectReg(5'd16, 8'h00, "R1");
    // R2 stopped, then enable without start
    runTicks(8);
    expectReg(5'd0, 8'h00, "R2");
    expectReg(5'd1, 8'h00, "R2");
    writeReg(4'd15, 8'h08);
    runTicks(4);
    expectReg(5'd1, 8'h00, "R2");
    // R2 running
    writeReg(4'd15, 8'h09);
    runTicks(3);
    expectReg(5'd0, 8'h03, "R2");
    expectReg(5'd1, 8'h00, "R2");
    runTicks(1);
    expectReg(5'd0, 8'h00, "R2");
    expectReg(5'd1, 8'h01, "R2");
    expectReg(5'd14, 8'h80, "R6");
    expectReg(5'd16, 8'h00, "R7");
    // R6 clear, R7 interrupt
    writeReg(4'd14, 8'h10);
    expectReg(5'd14, 8'h10, "R6");
    expectReg(5'd16, 8'h00, "R7");
    runTicks(4);
    expectReg(5'd1, 8'h02, "R2");
    expectReg(5'd14, 8'h90, "R6");
    expectReg(5'd16, 8'h01, "R7");
    writeReg(4'd14, 8'h90);
    expectReg(5'd14, 8'h90, "R6");
    writeReg(4'd14, 8'h00);
    expectReg(5'd14, 8'h00, "R6");
    expectReg(5'd16, 8'h00, "R7");
    // R8 prescaler reset
    runTicks(2);
    expectReg(5'd0, 8'h02, "R8");
    writeReg(4'd15, 8'h0B);
    expectReg(5'd0, 8'h00, "R8");
    expectReg(5'd15, 8'h09, "R8");
    expectReg(5'd1, 8'h02, "R8");
    // R11 digit carry on seconds
    runTicks(36);
    expectReg(5'd1, 8'h11, "R11");
    // R3 R4 full rollover
    setTime(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    runTicks(4);
    expectReg(5'd1, 8'h00, "R3");
    expectReg(5'd2, 8'h00, "R3");
    expectReg(5'd3, 8'h00, "R3");
    expectReg(5'd4, 8'h00, "R3");
    expectReg(5'd5, 8'h01, "R4");
    expectReg(5'd6, 8'h01, "R4");
    expectReg(5'd7, 8'h00, "R4");
    // R5 non-leap February
    setTime(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    runTicks(4);
    expectReg(5'd5, 8'h01, "R5");
    expectReg(5'd6, 8'h03, "R5");
    // R5 leap February
    setTime(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    runTicks(4);
    expectReg(5'd5, 8'h29, "R5");
    expectReg(5'd6, 8'h02, "R5");
    expectReg(5'd4, 8'h03, "R3");
    setTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    runTicks(4);
    expectReg(5'd5, 8'h01, "R5");
    expectReg(5'd6, 8'h03, "R5");
    // R4 month lengths
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
    runTicks(4);
    expectReg(5'd5, 8'h01, "R4");
    expectReg(5'd6, 8'h05, "R4");
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h07, 8'h24);
    runTicks(4);
    expectReg(5'd5, 8'h31, "R4");
    expectReg(5'd6, 8'h07, "R4");
    // R11 digit carries in day and hour
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h09, 8'h05, 8'h24);
    runTicks(4);
    expectReg(5'd5, 8'h10, "R11");
    setTime(8'h59, 8'h59, 8'h09, 8'h01, 8'h09, 8'h05, 8'h24);
    runTicks(4);
    expectReg(5'd3, 8'h10, "R11");
    expectReg(5'd5, 8'h09, "R11");
    // R9 rounding
    writeReg(4'd15, 8'h00);
    writeReg(4'd1, 8'h29);
    writeReg(4'd2, 8'h10);
    writeReg(4'd15, 8'h04);
    expectReg(5'd1, 8'h00, "R9");
    expectReg(5'd2, 8'h10, "R9");
    expectReg(5'd15, 8'h00, "R9");
    writeReg(4'd1, 8'h30);
    writeReg(4'd15, 8'h04);
    expectReg(5'd1, 8'h00, "R9");
    expectReg(5'd2, 8'h11, "R9");
    writeReg(4'd1, 8'h45);
    writeReg(4'd2, 8'h59);
    writeReg(4'd3, 8'h05);
    writeReg(4'd15, 8'h04);
    expectReg(5'd1, 8'h00, "R9");
    expectReg(5'd2, 8'h00, "R9");
    expectReg(5'd3, 8'h06, "R9");
    // R10 unused indices
    writeReg(4'd8, 8'h55);
    expectReg(5'd8, 8'h00, "R10");
    writeReg(4'd13, 8'hAA);
    expectReg(5'd13, 8'h00, "R10");
    expectReg(5'd3, 8'h06, "R10");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule